// File: doc/BRIEF.md
# Segmented Delay Counter with Tap Select

This block is the counting core of a programmable delay timer. A 24-stage binary counter advances once for each cycle in which the count tick is high. A 4-bit select code names one stage as the delay tap. Each time that stage's bit falls from one to zero, the block emits a one-cycle terminal pulse, so the delay is a power of two between 2 and 2^24 ticks. The trigger logic around the block issues a synchronous clear on every trigger or retrigger. An asynchronous clear zeroes everything at once.

The top select bit also sets how the chain is wired. When it is high, the three 8-bit segments are cascaded: each segment's carry enables the next one, and the counter runs through the whole 24-bit range. When it is low, the segments count side by side from the same tick. After 255 ticks in this split mode every stage holds one. Raising the top select bit and giving one more tick then drives a carry through all 24 stages. This exercises the whole chain in 256 ticks instead of 2^24. The full counter state is brought out for observation.

Top module: `seg_delay_counter`

## Requirements
- R1: With select bit 3 low, the tap is stage sel[2:0] (division 2^(sel[2:0]+1)). With select bit 3 high, the tap is stage 16+sel[2:0] (division 2^(sel[2:0]+17)). Stage k is count bit k.
- R2: With select bit 3 low (split mode), each tick adds one, modulo 256, to each of the segments count[7:0], count[15:8] and count[23:16] independently.
- R3: With select bit 3 high (chained mode), each tick adds one to the full 24-bit count, modulo 2^24.
- R4: `done` is high for exactly the one cycle after a clock edge at which the tap bit changed from one to zero. The new count is visible in that same cycle.
- R5: In a cycle with the tick low and no clear, count holds its value and `done` stays low.
- R6: The synchronous clear zeroes the count at the next edge. It wins over a tick in the same cycle and never produces `done`.
- R7: The asynchronous clear sets the count and `done` to zero at once, without waiting for a clock edge.
- R8: From zero, 255 ticks in split mode with select 0111 leave count at 0xFFFFFF. One further tick with select 1111 returns the count to zero and pulses `done`.
- R9: Changing the select code alone never alters the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clrAsync | input | 1 | Asynchronous clear, active high |
| clrSync | input | 1 | Synchronous clear (trigger/retrigger), active high |
| tick | input | 1 | Count enable for one clock cycle |
| sel | input | 4 | Tap select; bit 3 also chooses chained (1) or split (0) mode |
| done | output | 1 | One-cycle terminal pulse at the end of the selected delay |
| count | output | 24 | Full counter state |

## Verification
The hardest condition to reach is a fall of one of the upper tap bits (stages 16 to 23). In chained mode that takes up to 2^24 ticks, which no practical run can afford. The bench instead preloads the counter in split mode until every segment is full. It then switches to chained mode, under each of the eight upper select codes in turn, and gives the single tick that produces the full carry. Split-mode taps are swept exhaustively over two full periods each, against an arithmetic model of the segment counts.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Strobes from the control decode to the counting datapath
  typedef struct packed {
    logic clear;    // zero all stages at this edge
    logic advance;  // count this edge
    logic chained;  // segments cascaded (1) or parallel (0)
  } dlyStrobe_t;
endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int TOTAL_W = 24,
  parameter int IDX_W   = $clog2(TOTAL_W)
) (
  input  logic             tick,
  input  logic             clrSync,
  input  logic [SEL_W-1:0] sel,
  output dlyStrobe_t       strobe,
  output logic [IDX_W-1:0] tapIdx
);
  localparam int LOW_W     = SEL_W - 1;
  localparam int HIGH_BASE = TOTAL_W - (1 << LOW_W);

  logic modeHigh;
  logic [IDX_W-1:0] lowIdx;

  assign modeHigh = sel[SEL_W-1];
  assign lowIdx   = IDX_W'(sel[LOW_W-1:0]);

  always_comb begin
    strobe.clear   = clrSync;
    strobe.advance = tick & ~clrSync;
    strobe.chained = modeHigh;
    if (modeHigh) tapIdx = IDX_W'(HIGH_BASE) + lowIdx;
    else          tapIdx = lowIdx;
  end

  // R1
  tap_range_chk: assert property (@(posedge tick) tapIdx < IDX_W'(TOTAL_W));
endmodule

// File: rtl/dly_path.sv
module dly_path
  import dly_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int TOTAL_W = SEG_W * NUM_SEG,
  parameter int IDX_W   = $clog2(TOTAL_W)
) (
  input  logic               clk,
  input  logic               clrAsync,
  input  dlyStrobe_t         strobe,
  input  logic [IDX_W-1:0]   tapIdx,
  output logic [TOTAL_W-1:0] count,
  output logic               done
);
  logic [NUM_SEG-1:0] segFull;
  logic [NUM_SEG-1:0] carryIn;
  logic [NUM_SEG-1:0] segEn;
  logic [TOTAL_W-1:0] nextCount;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [SEG_W-1:0] segQ;
    logic [SEG_W-1:0] segD;

    assign segFull[g] = &segQ;
    if (g == 0) begin : g_first
      assign carryIn[g] = 1'b1;
    end else begin : g_rest
      assign carryIn[g] = carryIn[g-1] & segFull[g-1];
    end
    assign segEn[g] = strobe.advance & (~strobe.chained | carryIn[g]);

    always_comb begin
      if (strobe.clear)   segD = '0;
      else if (segEn[g])  segD = segQ + 1'b1;
      else                segD = segQ;
    end

    always_ff @(posedge clk or posedge clrAsync) begin
      if (clrAsync) segQ <= '0;
      else          segQ <= segD;
    end

    assign count[g*SEG_W +: SEG_W]     = segQ;
    assign nextCount[g*SEG_W +: SEG_W] = segD;
  end

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) done <= 1'b0;
    else          done <= ~strobe.clear & count[tapIdx] & ~nextCount[tapIdx];
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (clrAsync)
    strobe.clear |=> (count == '0) && !done);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (clrAsync)
    (!strobe.advance && !strobe.clear) |=> $stable(count) && !done);

  // R3
  chain_step_chk: assert property (@(posedge clk) disable iff (clrAsync)
    (strobe.advance && strobe.chained) |=> count == $past(count) + 1'b1);

  // R2
  split_step_chk: assert property (@(posedge clk) disable iff (clrAsync)
    (strobe.advance && !strobe.chained) |=>
      count[SEG_W-1:0] == SEG_W'($past(count[SEG_W-1:0]) + 1'b1));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (clrAsync)
    done |=> !done);

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (clrAsync)
    done |-> $past(strobe.advance));
endmodule

// File: rtl/seg_delay_counter.sv
module seg_delay_counter
  import dly_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int SEL_W   = 4,
  parameter int TOTAL_W = SEG_W * NUM_SEG
) (
  input  logic               clk,
  input  logic               clrAsync,
  input  logic               clrSync,
  input  logic               tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               done,
  output logic [TOTAL_W-1:0] count
);
  localparam int IDX_W = $clog2(TOTAL_W);

  dlyStrobe_t       strobe;
  logic [IDX_W-1:0] tapIdx;

  dly_ctrl #(.SEL_W(SEL_W), .TOTAL_W(TOTAL_W), .IDX_W(IDX_W)) u_ctrl (
    .tick(tick), .clrSync(clrSync), .sel(sel),
    .strobe(strobe), .tapIdx(tapIdx)
  );

  dly_path #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .TOTAL_W(TOTAL_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .clrAsync(clrAsync), .strobe(strobe), .tapIdx(tapIdx),
    .count(count), .done(done)
  );

  // R7
  async_clear_chk: assert property (@(posedge clk) clrAsync |-> (count == '0) && !done);
endmodule

// File: tb/seg_delay_counter_bench.sv
module seg_delay_counter_bench;
  logic        clk = 1'b0;
  logic        clrAsync = 1'b1;
  logic        clrSync = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  sel = 4'd0;
  logic        done;
  logic [23:0] count;

  int checks = 0;
  int fails = 0;
  logic [23:0] expCount = '0;

  always #2 clk = ~clk;

  seg_delay_counter u_seg_delay_counter (
    .clk(clk), .clrAsync(clrAsync), .clrSync(clrSync), .tick(tick),
    .sel(sel), .done(done), .count(count)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R1: tap index from the select code
  function automatic int tapOf(input logic [3:0] s);
    return s[3] ? 16 + int'(s[2:0]) : int'(s[2:0]);
  endfunction

  // R2 / R3 / R6 model
  function automatic logic [23:0] model(input logic [23:0] old, input logic [3:0] s,
                                         input logic tk, input logic cs);
    logic [23:0] n;
    if (cs) return '0;
    if (!tk) return old;
    if (s[3]) return old + 24'd1;
    for (int k = 0; k < 3; k++) n[k*8 +: 8] = old[k*8 +: 8] + 8'd1;
    return n;
  endfunction

  task automatic step(input logic tk, input logic cs, input string tag);
    logic [23:0] nxt;
    logic expDone;
    int t;
    @(negedge clk);
    tick = tk; clrSync = cs;
    nxt = model(expCount, sel, tk, cs);
    t = tapOf(sel);
    expDone = !cs && expCount[t] && !nxt[t];
    @(posedge clk); #1;
    chk({tag, " count"}, 32'(count), 32'(nxt));
    chk({tag, " done"}, 32'(done), 32'(expDone));
    expCount = nxt;
  endtask

  task automatic preload(input int n, input logic [3:0] s);
    sel = s;
    step(0, 1, "R6 clear");
    for (int i = 0; i < n; i++) step(1, 0, "R2 preload");
  endtask

  initial begin
    // R7 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset count", 32'(count), 0);
    chk("R7 reset done", 32'(done), 0);
    @(negedge clk); clrAsync = 1'b0;

    // R1 R2 R4 split-mode taps, two full periods each
    for (int s = 0; s < 8; s++) begin
      sel = 4'(s);
      step(0, 1, "R6 clear");
      for (int i = 0; i < (4 << s); i++) step(1, 0, "R1 R2 R4 split tap");
    end

    // R5 idle cycles hold
    for (int i = 0; i < 5; i++) step(0, 0, "R5 hold");

    // R3 chained counting across segment carries
    sel = 4'b1000;
    step(0, 1, "R6 clear");
    for (int i = 0; i < 600; i++) step(1, 0, "R3 chained");
    chk("R3 chained value", 32'(count), 600);

    // R8 fast test sequence
    preload(255, 4'b0111);
    chk("R8 preload all ones", 32'(count), 32'h00FF_FFFF);
    sel = 4'b1111;
    step(1, 0, "R8 full carry");
    chk("R8 rollover zero", 32'(count), 0);

    // R9 mode change alone keeps the state
    preload(5, 4'b0000);
    sel = 4'b1000;
    step(0, 0, "R9 mode switch");
    chk("R9 retained", 32'(count), 32'h0005_0505);
    step(1, 0, "R3 R9 continue chained");
    chk("R9 chained next", 32'(count), 32'h0005_0506);

    // R1 R4 upper taps through preload and a full carry
    for (int s = 0; s < 8; s++) begin
      preload(255, 4'b0111);
      sel = 4'(8 + s);
      step(1, 0, "R1 R4 upper tap");
      chk("R1 upper tap done", 32'(done), 1);
      step(1, 0, "R4 pulse width");
    end

    // R6 sync clear beats a tick at the rollover point
    preload(255, 4'b0111);
    sel = 4'b1111;
    step(1, 1, "R6 clear over tick");

    // R7 async clear mid-run
    preload(40, 4'b1000);
    step(0, 0, "R5 hold");
    @(negedge clk);
    clrAsync = 1'b1;
    #1;
    chk("R7 async count", 32'(count), 0);
    chk("R7 async done", 32'(done), 0);
    @(posedge clk);
    @(negedge clk);
    clrAsync = 1'b0;
    expCount = '0;
    step(1, 0, "R3 after async");

    finish_run();
  end
endmodule